// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures how long one fan tachometer period lasts. A reference tick enable, typically a 50 kHz strobe, is divided by 2, 4, 8 or 16 to form a count clock. The block counts count-clock ticks between successive rising edges of the tach signal. The tach input arrives from the pin asynchronously and is resynchronised inside the block. The most recent completed count is held in an 8-bit result register, so a slow or stopped fan reads as a large number.

A stalled rotor never produces the edge that would end its period. For that case the result register jumps to 255 the moment the running count passes its limit, with no wait for a tach edge. An optional fault flag latches on that overflow. Software can clear the flag with a strobe, or by dropping the enable. The flag sets again while the overflow persists. One instance serves one fan, so a two-fan controller places two.

Top module: `fan_period_meter`

## Requirements
- R1: `div_sel` picks the count-clock ratio from reference ticks as 2'b11 → ÷2, 2'b10 → ÷4, 2'b01 → ÷8 and 2'b00 → ÷16. Cycles with `ref_tick` low advance nothing.
- R2: Each detected rising tach edge restarts the prescaler and the counter. A reference tick in that same cycle is not counted. With N reference ticks strictly between two detected edges, the next result is floor(N / ratio).
- R3: After reset, `period_o` reads 255 (all ones) and `fault_o` reads 0.
- R4: `tach_in` passes through a two-flop synchroniser. Only a low-to-high transition counts as an edge, and the edge pulse lasts one cycle.
- R5: The first rising edge after reset starts a period but does not change `period_o`.
- R6: A count tick that arrives while the counter already holds 255 is an overflow. `period_o` becomes 255 on that clock edge, with no tach edge needed. The counter then holds until the next rising edge, and that edge copies nothing.
- R7: `fault_o` sets on overflow only while `flt_en` is high. With `flt_en` low it stays 0.
- R8: A high `flt_clr` or a low `flt_en` clears `fault_o` on the next edge. If the overflow is still in force one cycle later, with `flt_en` high and `flt_clr` low, the flag sets again.
- R9: A full count of exactly 255 is a valid result and raises no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | Reference tick enable, one cycle per reference period |
| div_sel | input | 2 | Count-clock divide select (see R1) |
| tach_in | input | 1 | Raw fan tachometer signal, asynchronous |
| flt_en | input | 1 | Enables the overflow fault |
| flt_clr | input | 1 | One-cycle strobe that clears the fault |
| period_o | output | 8 | Last completed period count, saturating at 255 |
| fault_o | output | 1 | Latched overflow fault |

## Verification
The bench sweeps every divide setting across tach periods of 4 to 40 clocks. It also drives the exact limit, where a count of 255 is legal, and one clock past it, where overflow must fire. Either an off-by-one prescaler or a counter that flags overflow at 255 would show up there. A stalled tach is held past the overflow point. This catches a design that waits for the next edge before saturating, and one whose fault fails to re-arm after a clear or an enable toggle. Two further cases are checked: the first edge after reset must not publish a partial count, and a gated-off reference tick must leave a zero count.

// File: rtl/fanp_pkg.sv
package fanp_pkg;

    localparam int unsigned CNT_W_DEF  = 8;
    localparam int unsigned SEL_W_DEF  = 2;
    localparam int unsigned SYNC_N_DEF = 2;

    // Per-cycle events passed from the front end to the counting core.
    typedef struct packed {
        logic rise;
        logic tick;
    } fanp_evt_t;

endpackage

// File: rtl/fanp_tach_sync.sv
module fanp_tach_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tach_i,
    output logic rise_o
);
    localparam int CHAIN_W = SYNC_N + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[CHAIN_W-2:0], tach_i};
        rise_o     = st_q.chain[CHAIN_W-2] & ~st_q.chain[CHAIN_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/fanp_prescale.sv
module fanp_prescale #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             restart_i,
    output logic             tick_o
);
    localparam int DIV_W = 1 << SEL_W;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } pre_st_t;

    pre_st_t          st_d, st_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        st_d   = st_q;
        // 00 -> 15 (divide by 16), 11 -> 1 (divide by 2)
        lim    = {DIV_W{1'b1}} >> sel_i;
        tick_o = ref_tick_i && !restart_i && (st_q.div >= lim);
        if (restart_i)       st_d.div = '0;
        else if (tick_o)     st_d.div = '0;
        else if (ref_tick_i) st_d.div = st_q.div + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (st_q.div == '0));

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_tick_i && !restart_i) |=> $stable(st_q.div));

endmodule

// File: rtl/fanp_period_core.sv
module fanp_period_core #(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  fanp_pkg::fanp_evt_t evt_i,
    input  logic               flt_en_i,
    input  logic               flt_clr_i,
    output logic [CNT_W-1:0]   res_o,
    output logic               fault_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] res;
        logic             ovf;
        logic             armed;
        logic             fault;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     ovf_evt;

    always_comb begin
        st_d    = st_q;
        ovf_evt = 1'b0;
        if (evt_i.rise) begin
            if (st_q.armed && !st_q.ovf) st_d.res = st_q.cnt;
            st_d.cnt   = '0;
            st_d.ovf   = 1'b0;
            st_d.armed = 1'b1;
        end else if (evt_i.tick) begin
            if (st_q.cnt == CNT_MAX) begin
                ovf_evt  = !st_q.ovf;
                st_d.ovf = 1'b1;
                st_d.res = CNT_MAX;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (!flt_en_i || flt_clr_i)   st_d.fault = 1'b0;
        else if (st_q.ovf || ovf_evt) st_d.fault = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.res   <= CNT_MAX;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o   = st_q.res;
    assign fault_o = st_q.fault;

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_i.rise && !evt_i.tick) |=> $stable(res_o));

    p_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |-> (res_o == CNT_MAX));

    p_no_fault_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_en_i |=> !fault_o);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flt_clr_i |=> !fault_o);

    p_refire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_en_i && !flt_clr_i && st_q.ovf) |=> fault_o);

endmodule

// File: rtl/fan_period_meter.sv
module fan_period_meter #(
    parameter int CNT_W  = fanp_pkg::CNT_W_DEF,
    parameter int SEL_W  = fanp_pkg::SEL_W_DEF,
    parameter int SYNC_N = fanp_pkg::SYNC_N_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             tach_in,
    input  logic             flt_en,
    input  logic             flt_clr,
    output logic [CNT_W-1:0] period_o,
    output logic             fault_o
);
    fanp_pkg::fanp_evt_t evt;

    fanp_tach_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .tach_i (tach_in),
        .rise_o (evt.rise)
    );

    fanp_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick_i (ref_tick),
        .sel_i      (div_sel),
        .restart_i  (evt.rise),
        .tick_o     (evt.tick)
    );

    fanp_period_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .flt_en_i  (flt_en),
        .flt_clr_i (flt_clr),
        .res_o     (period_o),
        .fault_o   (fault_o)
    );

endmodule

// File: tb/tb_fan_period_meter.sv
module tb_fan_period_meter;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ref_tick;
    logic [1:0] div_sel;
    logic       tach_in;
    logic       flt_en;
    logic       flt_clr;
    logic [7:0] period_o;
    logic       fault_o;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fan_period_meter dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .div_sel  (div_sel),
        .tach_in  (tach_in),
        .flt_en   (flt_en),
        .flt_clr  (flt_clr),
        .period_o (period_o),
        .fault_o  (fault_o)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ratio_of(input int sel);
        return 2 << (3 - sel);
    endfunction

    // Three tach periods of p clocks; fault clear strobe at the start of the third.
    task automatic run_period(input int sel, input int p);
        div_sel = sel[1:0];
        for (int k = 0; k < 3; k++) begin
            tach_in = 1'b1;
            if (k == 2) begin
                flt_clr = 1'b1;
                cyc(1);
                flt_clr = 1'b0;
                cyc(p / 2 - 1);
            end else begin
                cyc(p / 2);
            end
            tach_in = 1'b0;
            cyc(p - p / 2);
        end
    endtask

    initial begin
        cyc(WATCHDOG);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ref_tick = 1'b1; div_sel = 2'b00; tach_in = 1'b0;
        flt_en = 1'b0; flt_clr = 1'b0;
        cyc(3);
        chk("R3 period after reset", period_o, 255);
        chk("R3 fault after reset", fault_o, 0);
        rst_n = 1'b1;
        cyc(2);
        chk("R3 period idle", period_o, 255);

        // R5: first edge after reset publishes nothing
        div_sel = 2'b11;
        tach_in = 1'b1; cyc(5); tach_in = 1'b0; cyc(5);
        chk("R5 first edge no update", period_o, 255);
        tach_in = 1'b1; cyc(5); tach_in = 1'b0; cyc(5);
        chk("R2 first full period div2", period_o, 4);

        // R1/R2 sweep over all ratios, no overflow expected (R7 enable high)
        flt_en = 1'b1;
        for (int s = 0; s < 4; s++) begin
            for (int p = 4; p <= 40; p++) begin
                run_period(s, p);
                chk($sformatf("R1 R2 sel=%0d p=%0d", s, p), period_o, (p - 1) / ratio_of(s));
                chk($sformatf("R7 no fault sel=%0d p=%0d", s, p), fault_o, 0);
            end
        end

        // R9 / R6 boundaries per ratio
        for (int s = 0; s < 4; s++) begin
            run_period(s, 256 * ratio_of(s));
            chk($sformatf("R9 exact 255 sel=%0d", s), period_o, 255);
            chk($sformatf("R9 no fault at 255 sel=%0d", s), fault_o, 0);
            run_period(s, 256 * ratio_of(s) + 1);
            chk($sformatf("R6 overflow value sel=%0d", s), period_o, 255);
            chk($sformatf("R7 overflow fault sel=%0d", s), fault_o, 1);
        end

        // R6 stalled rotor saturates without an edge
        run_period(3, 20);
        chk("R2 pre-stall count", period_o, 9);
        chk("R7 pre-stall fault", fault_o, 0);
        cyc(400);
        chk("R6 before overflow", period_o, 9);
        cyc(200);
        chk("R6 stall saturates", period_o, 255);
        chk("R7 stall fault", fault_o, 1);

        // R8 clear strobe and re-fire
        flt_clr = 1'b1; cyc(1); flt_clr = 1'b0;
        chk("R8 cleared by strobe", fault_o, 0);
        cyc(1);
        chk("R8 refires while overflowed", fault_o, 1);

        // R8/R7 clear through enable
        flt_en = 1'b0; cyc(1);
        chk("R8 cleared by enable low", fault_o, 0);
        cyc(5);
        chk("R7 stays low while disabled", fault_o, 0);
        flt_en = 1'b1; cyc(1);
        chk("R8 sets on re-enable in overflow", fault_o, 1);

        // R6 recovery after overflow
        run_period(3, 20);
        chk("R6 recovery count", period_o, 9);
        chk("R8 fault clear after recovery", fault_o, 0);

        // R1 gated reference tick
        ref_tick = 1'b0;
        run_period(0, 30);
        chk("R1 no ref ticks gives zero", period_o, 0);
        ref_tick = 1'b1;

        // R4 falling edge alone does not update
        run_period(2, 24);
        chk("R4 baseline div4", period_o, 5);
        tach_in = 1'b1; cyc(3);
        chk("R4 held high no extra update", period_o, 5);
        tach_in = 1'b0; cyc(3);
        chk("R4 falling edge no update", period_o, 5);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule